// File: doc/BRIEF.md
# Four-Stage Macroblock Pipeline Scheduler

This block orders the work of a four-stage video encoder pipeline. The stages run in a fixed order: integer motion search first, then fractional motion refinement, then intra prediction with reconstruction, and last a combined entropy-coding and deblocking stage. Macroblocks enter in raster order. All four stages move together on one shared pipeline step, so while macroblock n sits in the search stage, n-1, n-2 and n-3 sit in the three stages behind it. The stage datapaths are outside this block. Each stage is driven by a one-cycle start pulse and answers with a one-cycle done pulse. The done of the entropy stage may come after any number of cycles.

A frame begins with a `frame_start` pulse that carries the frame size in macroblocks. A fixed initialization wait follows, and then the first macroblock is issued. The search and refinement stages share one search-window buffer. For that reason, one bubble (an empty work slot) goes into the first stage ahead of the first macroblock of every row except the first. The bubble moves down the pipeline like a macroblock but starts no work. The first macroblock of each row is flagged for a full window reload. When the last macroblock has been issued, the pipeline drains with empty slots. A single `frame_done` pulse ends the frame.

Top module: `mb_pipe_sched`

## Requirements
- R1: After reset every output is 0 and the block is idle (`busy` = 0).
- R2: `frame_start` is sampled in the cycle it is high. The first `stage_start[0]` pulse of a non-empty frame is high in the (INIT_CYCLES+1)-th cycle after that cycle.
- R3: At each step, stage k takes the slot that stage k-1 held. Stage 0 takes the next issue entry. Macroblocks are issued with numbers 0 to W*H-1 in raster order (number = row*W + column). `stage_vld[k]` = 1 and `stage_mb[k]` = number while stage k holds a macroblock. Otherwise `stage_mb[k]` = 0.
- R4: One bubble is issued just before the first macroblock of every row except row 0. A frame therefore holds H-1 bubbles. While stage k holds a bubble, `stage_bub[k]` = 1, `stage_vld[k]` = 0 and no start goes to stage k.
- R5: `full_reload` is 1 exactly while stage 0 holds a macroblock from column 0.
- R6: One cycle after every step that leaves the pipeline not empty, `stage_start` pulses for one cycle on exactly the stages with `stage_vld` = 1.
- R7: The pipeline steps only once every stage holding a macroblock has given its done pulse since its start. A done pulse is remembered until the step.
- R8: After the last macroblock leaves stage 3, `frame_done` is 1 for exactly one cycle and `busy` is 0 from that cycle on.
- R9: A frame with width 0 or height 0 issues no start pulse. It still gives one `frame_done` pulse after the initialization wait.
- R10: `frame_start` and the size inputs are ignored while `busy` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| frame_start | input | 1 | Starts a frame when idle |
| frame_w | input | 8 | Frame width in macroblocks, sampled with frame_start |
| frame_h | input | 8 | Frame height in macroblocks, sampled with frame_start |
| stage_done | input | 4 | Per-stage done pulse (bit 0 = search, bit 3 = entropy/deblock) |
| stage_start | output | 4 | Per-stage start pulse |
| stage_vld | output | 4 | Stage holds a macroblock |
| stage_bub | output | 4 | Stage holds a bubble |
| stage_mb | output | 4x16 | Macroblock number held by each stage |
| full_reload | output | 1 | Search stage must reload its whole window |
| busy | output | 1 | A frame is in progress |
| frame_done | output | 1 | One-cycle end-of-frame pulse |

## Verification
The bench compares the occupancy of every stage at every step with a raster model that places bubbles between rows. A wrong bubble position or a missing bubble breaks the match with that model. The entropy stage is given a latency that depends on the macroblock. A design that stepped on the first done, or forgot a done that came early, would step while a stage still owes its done, and the bench catches that. Single-row, single-column and zero-size frames test the row-wrap, bubble and drain edges. A `frame_start` pulse arrives in the middle of a frame; a design that restarted on it would lose the raster sequence. The bench also counts the initialization wait, the number of reload flags and the width of the frame-done pulse.

// File: rtl/mb_sched_pkg.sv
package mb_sched_pkg;

    localparam int MB_NUM_W = 16;

    typedef enum logic [1:0] {
        SLOT_EMPTY = 2'd0,
        SLOT_MB    = 2'd1,
        SLOT_BUB   = 2'd2
    } slot_kind_e;

    typedef struct packed {
        slot_kind_e            kind;
        logic [MB_NUM_W-1:0]   num;
        logic                  first;
    } slot_t;

    typedef enum logic [1:0] {
        SCH_IDLE  = 2'd0,
        SCH_INIT  = 2'd1,
        SCH_ISSUE = 2'd2,
        SCH_WAIT  = 2'd3
    } sch_state_e;

endpackage

// File: rtl/mb_raster_issue.sv
module mb_raster_issue
    import mb_sched_pkg::*;
#(
    parameter int DIM_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [DIM_W-1:0] width_i,
    input  logic [DIM_W-1:0] height_i,
    input  logic             advance,
    output slot_t            entry_o
);

    typedef struct packed {
        logic [DIM_W-1:0]    col;
        logic [DIM_W-1:0]    row;
        logic [DIM_W-1:0]    wid;
        logic [DIM_W-1:0]    hgt;
        logic [MB_NUM_W-1:0] num;
        logic                bub;
        logic                left;
    } iss_t;

    iss_t iss_d, iss_q;

    always_comb begin
        iss_d = iss_q;
        if (load) begin
            iss_d.col  = '0;
            iss_d.row  = '0;
            iss_d.num  = '0;
            iss_d.bub  = 1'b0;
            iss_d.wid  = width_i;
            iss_d.hgt  = height_i;
            iss_d.left = (width_i != '0) && (height_i != '0);
        end else if (advance && iss_q.left) begin
            if (iss_q.bub) begin
                iss_d.bub = 1'b0;
            end else begin
                iss_d.num = iss_q.num + MB_NUM_W'(1);
                if (iss_q.col == iss_q.wid - DIM_W'(1)) begin
                    iss_d.col = '0;
                    if (iss_q.row == iss_q.hgt - DIM_W'(1)) begin
                        iss_d.left = 1'b0;
                    end else begin
                        iss_d.row = iss_q.row + DIM_W'(1);
                        iss_d.bub = 1'b1;
                    end
                end else begin
                    iss_d.col = iss_q.col + DIM_W'(1);
                end
            end
        end
    end

    always_comb begin
        entry_o       = '0;
        entry_o.kind  = SLOT_EMPTY;
        if (iss_q.left) begin
            if (iss_q.bub) begin
                entry_o.kind = SLOT_BUB;
            end else begin
                entry_o.kind  = SLOT_MB;
                entry_o.num   = iss_q.num;
                entry_o.first = (iss_q.col == '0);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) iss_q <= '0;
        else        iss_q <= iss_d;
    end

endmodule

// File: rtl/mb_slot_chain.sv
module mb_slot_chain
    import mb_sched_pkg::*;
#(
    parameter int DEPTH = 4
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  slot_t entry_i,
    output slot_t slots_o [DEPTH]
);

    slot_t slot_d [DEPTH];
    slot_t slot_q [DEPTH];

    always_comb begin
        for (int k = 0; k < DEPTH; k++) slot_d[k] = slot_q[k];
        if (step) begin
            slot_d[0] = entry_i;
            for (int k = 1; k < DEPTH; k++) slot_d[k] = slot_q[k-1];
        end
    end

    for (genvar k = 0; k < DEPTH; k++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q[k] <= '0;
            else        slot_q[k] <= slot_d[k];
        end
        assign slots_o[k] = slot_q[k];
    end

endmodule

// File: rtl/mb_done_track.sv
module mb_done_track #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [N-1:0] need,
    input  logic [N-1:0] done_i,
    output logic         all_done
);

    logic [N-1:0] seen_d, seen_q;

    always_comb begin
        seen_d   = step ? '0 : (seen_q | done_i);
        all_done = &(seen_q | done_i | ~need);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen_q <= '0;
        else        seen_q <= seen_d;
    end

endmodule

// File: rtl/mb_pipe_sched.sv
module mb_pipe_sched
    import mb_sched_pkg::*;
#(
    parameter int STAGES      = 4,
    parameter int DIM_W       = 8,
    parameter int INIT_CYCLES = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             frame_start,
    input  logic [DIM_W-1:0]                 frame_w,
    input  logic [DIM_W-1:0]                 frame_h,
    input  logic [STAGES-1:0]                stage_done,
    output logic [STAGES-1:0]                stage_start,
    output logic [STAGES-1:0]                stage_vld,
    output logic [STAGES-1:0]                stage_bub,
    output logic [STAGES-1:0][MB_NUM_W-1:0]  stage_mb,
    output logic                             full_reload,
    output logic                             busy,
    output logic                             frame_done
);

    localparam int CNT_W = $clog2(INIT_CYCLES + 1);

    typedef struct packed {
        sch_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic             fdone;
    } ctl_t;

    ctl_t  ctl_d, ctl_q;
    logic  step;
    logic  load;
    logic  all_done;
    logic  frame_end;
    slot_t entry;
    slot_t slots [STAGES];

    mb_raster_issue #(.DIM_W(DIM_W)) u_issue (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load),
        .width_i (frame_w),
        .height_i(frame_h),
        .advance (step),
        .entry_o (entry)
    );

    mb_slot_chain #(.DEPTH(STAGES)) u_chain (
        .clk    (clk),
        .rst_n  (rst_n),
        .step   (step),
        .entry_i(entry),
        .slots_o(slots)
    );

    mb_done_track #(.N(STAGES)) u_done (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (step),
        .need    (stage_vld),
        .done_i  (stage_done),
        .all_done(all_done)
    );

    for (genvar k = 0; k < STAGES; k++) begin : g_out
        assign stage_vld[k] = (slots[k].kind == SLOT_MB);
        assign stage_bub[k] = (slots[k].kind == SLOT_BUB);
        assign stage_mb[k]  = stage_vld[k] ? slots[k].num : '0;
    end

    // pipeline is empty after this step when no macroblock moves on and none enters
    always_comb begin
        frame_end = (entry.kind == SLOT_EMPTY);
        for (int k = 0; k < STAGES - 1; k++) begin
            if (slots[k].kind == SLOT_MB) frame_end = 1'b0;
        end
    end

    always_comb begin
        ctl_d       = ctl_q;
        ctl_d.fdone = 1'b0;
        step        = 1'b0;
        load        = 1'b0;
        unique case (ctl_q.st)
            SCH_IDLE: begin
                if (frame_start) begin
                    load      = 1'b1;
                    ctl_d.cnt = '0;
                    ctl_d.st  = SCH_INIT;
                end
            end
            SCH_INIT: begin
                ctl_d.cnt = ctl_q.cnt + CNT_W'(1);
                if (ctl_q.cnt == CNT_W'(INIT_CYCLES - 1)) step = 1'b1;
            end
            SCH_ISSUE: ctl_d.st = SCH_WAIT;
            SCH_WAIT:  step = all_done;
            default:   ctl_d.st = SCH_IDLE;
        endcase
        if (step) begin
            if (frame_end) begin
                ctl_d.st    = SCH_IDLE;
                ctl_d.fdone = 1'b1;
            end else begin
                ctl_d.st = SCH_ISSUE;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: SCH_IDLE, cnt: '0, fdone: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign stage_start = (ctl_q.st == SCH_ISSUE) ? stage_vld : '0;
    assign full_reload = stage_vld[0] && slots[0].first;
    assign busy        = (ctl_q.st != SCH_IDLE);
    assign frame_done  = ctl_q.fdone;

endmodule

// File: rtl/mb_pipe_sched_chk.sv
module mb_pipe_sched_chk
    import mb_sched_pkg::*;
#(
    parameter int STAGES = 4
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            step,
    input logic [STAGES-1:0]               stage_start,
    input logic [STAGES-1:0]               stage_vld,
    input logic [STAGES-1:0]               stage_bub,
    input logic [STAGES-1:0][MB_NUM_W-1:0] stage_mb,
    input logic                            full_reload,
    input logic                            busy,
    input logic                            frame_done
);

    a_r6_start_only_mb: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start & ~stage_vld) == '0);

    a_r6_start_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_start != '0) |=> (stage_start == '0));

    a_r5_reload_on_mb: assert property (@(posedge clk) disable iff (!rst_n)
        full_reload |-> stage_vld[0]);

    a_r4_mb_bub_excl: assert property (@(posedge clk) disable iff (!rst_n)
        (stage_vld & stage_bub) == '0);

    a_r3_shift_on_step: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (stage_vld[1] == $past(stage_vld[0])) && (stage_mb[1] == $past(stage_mb[0]))
                 && (stage_bub[1] == $past(stage_bub[0])));

    a_r7_hold_between_steps: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(stage_vld) && $stable(stage_bub) && $stable(stage_mb));

    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);

    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |-> !busy);

endmodule

bind mb_pipe_sched mb_pipe_sched_chk #(.STAGES(STAGES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .step       (step),
    .stage_start(stage_start),
    .stage_vld  (stage_vld),
    .stage_bub  (stage_bub),
    .stage_mb   (stage_mb),
    .full_reload(full_reload),
    .busy       (busy),
    .frame_done (frame_done)
);

// File: tb/sim_mb_pipe_sched.sv
module sim_mb_pipe_sched;

    localparam int INIT = 8;
    localparam int NST  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             frame_start = 1'b0;
    logic [7:0]       frame_w = '0;
    logic [7:0]       frame_h = '0;
    logic [3:0]       stage_done = '0;
    logic [3:0]       stage_start;
    logic [3:0]       stage_vld;
    logic [3:0]       stage_bub;
    logic [3:0][15:0] stage_mb;
    logic             full_reload;
    logic             busy;
    logic             frame_done;

    always #10 clk = ~clk;

    mb_pipe_sched #(.INIT_CYCLES(INIT)) u0 (.*);

    int errors = 0;
    int checks = 0;
    int pcnt   = 0;
    always @(posedge clk) pcnt <= pcnt + 1;

    // w, h, snapshots, bubbles, reloads, inject start while busy
    localparam int NV = 7;
    localparam int VEC [NV][6] = '{
        '{1, 1,  4, 0, 1, 0},
        '{4, 3, 17, 2, 3, 1},
        '{3, 2, 10, 1, 2, 0},
        '{1, 4, 10, 3, 4, 0},
        '{5, 1,  8, 0, 1, 0},
        '{0, 3,  0, 0, 0, 0},
        '{2, 0,  0, 0, 0, 0}
    };

    // model of issued entries: 0 empty, 1 macroblock, 2 bubble
    int ek [64];
    int en [64];
    int ne;

    int snap_cnt, bub_cnt, rel_cnt, fd_cycles, s3_starts, first_start, t0;
    logic [3:0] owe;
    int lat_cnt [NST];
    logic [71:0] prev_snap;

    task automatic chk(input bit ok, input string req, input string msg, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, msg, act, exp);
        end
    endtask

    task automatic build_model(input int w, input int h);
        ne = 0;
        if (w != 0 && h != 0) begin
            for (int r = 0; r < h; r++) begin
                if (r != 0) begin ek[ne] = 2; en[ne] = 0; ne++; end
                for (int c = 0; c < w; c++) begin ek[ne] = 1; en[ne] = r * w + c; ne++; end
            end
        end
    endtask

    // called once per negedge during a frame: monitor, then stage responders
    task automatic mon_step();
        logic [71:0] snap;
        bit ok;
        for (int i = 0; i < NST; i++) if (stage_done[i]) owe[i] = 1'b0;
        snap = {stage_vld, stage_bub, stage_mb};
        if (snap != prev_snap && snap != '0) begin
            snap_cnt++;
            chk(owe == 4'b0, "R7", "step before all done", owe, 0);
            ok = 1'b1;
            for (int k = 0; k < NST; k++) begin
                int idx = snap_cnt - 1 - k;
                int kd = (idx >= 0 && idx < ne) ? ek[idx] : 0;
                int nm = (kd == 1) ? en[idx] : 0;
                if (stage_vld[k] != (kd == 1) || stage_bub[k] != (kd == 2) || stage_mb[k] != 16'(nm)) begin
                    ok = 1'b0;
                    $display("FAIL R3 stage %0d snap %0d: vld=%0b bub=%0b mb=%0d expected kind=%0d mb=%0d",
                             k, snap_cnt, stage_vld[k], stage_bub[k], stage_mb[k], kd, nm);
                end
            end
            checks++;
            if (!ok) errors++;
            if (stage_bub[0]) bub_cnt++;
            chk(full_reload == (stage_vld[0] && (stage_mb[0] % frame_w_l == 0)), "R5",
                "reload flag", full_reload, 0);
            if (full_reload) rel_cnt++;
        end
        prev_snap = snap;
        if (stage_start != '0) begin
            chk(stage_start == stage_vld, "R6", "start mask", stage_start, stage_vld);
            if (first_start < 0 && stage_start[0]) first_start = pcnt - t0;
            if (stage_start[3]) s3_starts++;
        end
        if (frame_done) fd_cycles++;
        stage_done = '0;
        for (int i = 0; i < NST; i++) begin
            if (stage_start[i]) begin
                owe[i] = 1'b1;
                lat_cnt[i] = (i == 3) ? 1 + (stage_mb[3] % 4) * 3 : 2 + i;
            end else if (lat_cnt[i] != 0) begin
                lat_cnt[i]--;
                if (lat_cnt[i] == 0) stage_done[i] = 1'b1;
            end
        end
    endtask

    int frame_w_l = 1;

    task automatic run_frame(input int w, input int h, input int snaps, input int bubs,
                             input int rels, input int inj);
        int fd_at;
        build_model(w, h);
        frame_w_l = (w == 0) ? 1 : w;
        snap_cnt = 0; bub_cnt = 0; rel_cnt = 0; fd_cycles = 0; s3_starts = 0;
        first_start = -1; owe = '0; prev_snap = '0; fd_at = -1;
        for (int i = 0; i < NST; i++) lat_cnt[i] = 0;
        @(negedge clk);
        frame_w = 8'(w); frame_h = 8'(h); frame_start = 1'b1; t0 = pcnt;
        for (int n = 0; n < 4000; n++) begin
            @(negedge clk);
            frame_start = 1'b0;
            if (inj != 0 && n == 40) begin
                frame_w = 8'd7; frame_h = 8'd7; frame_start = 1'b1;
            end
            mon_step();
            if (frame_done && fd_at < 0) begin
                fd_at = n;
                chk(busy == 1'b0, "R8", "busy at frame_done", busy, 0);
                chk(stage_vld == 4'b0, "R8", "stages empty at frame_done", stage_vld, 0);
            end
            if (fd_at >= 0 && n >= fd_at + 3) break;
        end
        chk(fd_at >= 0, "R8", "frame_done seen", fd_at, 1);
        chk(fd_cycles == 1, "R8", "frame_done width", fd_cycles, 1);
        chk(snap_cnt == snaps, (inj != 0) ? "R10" : "R3", "step count", snap_cnt, snaps);
        chk(bub_cnt == bubs, "R4", "bubble count", bub_cnt, bubs);
        chk(rel_cnt == rels, "R5", "reload count", rel_cnt, rels);
        chk(s3_starts == w * h, "R6", "entropy stage starts", s3_starts, w * h);
        if (w * h != 0) chk(first_start == INIT + 1, "R2", "init wait", first_start, INIT + 1);
        else            chk(first_start == -1, "R9", "no start on empty frame", first_start, -1);
        chk(busy == 1'b0, "R8", "idle after frame", busy, 0);
    endtask

    bit finished = 0;

    initial begin
        #(20 * 200000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({stage_start, stage_vld, stage_bub} == '0, "R1", "stage flags in reset", 0, 0);
        chk(stage_mb == '0 && !full_reload && !busy && !frame_done, "R1", "outputs in reset", busy, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && stage_vld == '0 && stage_start == '0, "R1", "idle after reset", busy, 0);
        for (int v = 0; v < NV; v++)
            run_frame(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5]);
        // back-to-back frame after an injected start must still begin clean
        run_frame(2, 2, 8, 1, 2, 0);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule